// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It is clocked by the system clock and advances only on cycles where an external enable pulses at sixteen times the bit rate. The line idles high. A low level starts a character, and the receiver measures every later bit from that point. Each bit is settled by a vote among three samples around its centre. The character format is chosen at runtime: 5 to 9 data bits, parity off, even or odd, and one or two stop bits. The format is captured when each character starts.

A finished character is held in an output register with a valid strobe and four per-character status flags: a missing stop bit, a parity mismatch, disagreement among the samples, and loss of a later character. The consumer pulses an acknowledge to release the register. A character that completes while the register is still full is dropped, and the held character is marked as having lost a successor.

Top module: `async_char_rx`

## Requirements
- R1: While idle, a low line seen on an enable tick is taken as tick 0 of a start bit. If the line is high again at tick 8 of that bit, the receiver returns to idle and delivers nothing.
- R2: cfg_bits_i sets the data bit count. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. The first data bit received lands in data_o bit 0. Data bits beyond the count read as zero.
- R3: Each data, parity and stop bit is sampled at ticks 7, 8 and 9 of its 16-tick window, and the majority of the three sets the bit's value. A disturbance outside those ticks has no effect.
- R4: noise_o is set for a character if the three samples of any of its data, parity or stop bits disagree.
- R5: With cfg_par_en_i high, one parity bit follows the data bits. cfg_par_odd_i = 0 asks for an even count of ones over the data plus parity bit, and 1 asks for an odd count. par_err_o is set when the count does not match. With parity off, par_err_o stays 0.
- R6: frame_err_o is set when the first stop bit is decided low. The character is still delivered.
- R7: A character is delivered once its first stop bit is decided. The receiver rearms right away, so a second stop bit is treated as idle line, and characters sent back to back with two stop bits are all received.
- R8: valid_o, data_o and the flags hold until ack_i is high in a cycle with valid_o high. In the next cycle valid_o and all flags are 0.
- R9: If a character completes while valid_o is high and ack_i is low, that character is discarded. The held character keeps its data and gets overrun_o = 1.
- R10: After reset, valid_o, data_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| cfg_bits_i | input | 4 | Data bit count (5..9, clamped) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| ack_i | input | 1 | Releases the held character |
| data_o | output | 9 | Received data, first bit at bit 0 |
| valid_o | output | 1 | Held character is valid |
| frame_err_o | output | 1 | First stop bit was low |
| par_err_o | output | 1 | Parity mismatch |
| noise_o | output | 1 | Samples of some bit disagreed |
| overrun_o | output | 1 | A later character was lost |

## Verification
The noise flag is the hardest case to reach from the ports. It needs a disturbance that covers exactly one of the three centre ticks of one bit and leaves the majority unchanged. The bench drives the line one enable slot at a time, with each new level set just after an enable pulse. This lines up each slot with one sampling tick inside the receiver, so a one-slot flip can be placed on tick 8, where it should raise the flag, or on tick 6, where it should not. Overrun is reached by holding the acknowledge off over two full characters.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic frame_err;
    logic par_err;
    logic noise;
  } rx_flags_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;  // idle level
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srx_vote.sv
module srx_vote import srx_pkg::*; #(
  parameter  int OSR   = 16,
  localparam int CNT_W = $clog2(OSR),
  localparam int MID   = OSR / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             line_i,
  output logic             decide_o,
  output logic             bit_o,
  output logic             noisy_o
);

  logic s_early_q, s_mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_early_q <= 1'b1;
      s_mid_q   <= 1'b1;
    end else if (tick_i && active_i) begin
      if (cnt_i == CNT_W'(MID - 1)) s_early_q <= line_i;
      if (cnt_i == CNT_W'(MID))     s_mid_q   <= line_i;
    end
  end

  // third sample is the live line on the deciding tick
  assign decide_o = tick_i & active_i & (cnt_i == CNT_W'(MID + 1));
  assign bit_o    = maj3(s_early_q, s_mid_q, line_i);
  assign noisy_o  = (s_early_q != s_mid_q) | (s_mid_q != line_i);

  p_single_decide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_o |=> !decide_o);

endmodule

// File: rtl/srx_frame.sv
module srx_frame import srx_pkg::*; #(
  parameter  int OSR      = 16,
  parameter  int MIN_BITS = 5,
  parameter  int MAX_BITS = 9,
  localparam int CNT_W    = $clog2(OSR),
  localparam int IDX_W    = $clog2(MAX_BITS + 1),
  localparam int MID      = OSR / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                line_i,
  input  logic [IDX_W-1:0]    cfg_bits_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_odd_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output rx_flags_t           flags_o
);

  rx_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q, cnt_nx;
  logic [IDX_W-1:0]    idx_q, bits_q;
  logic                par_en_q, par_odd_q, par_bit_q, noise_acc_q;
  logic                decide, bit_v, noisy, sampling;

  assign sampling = (state_q == ST_DATA) || (state_q == ST_PAR) || (state_q == ST_STOP);
  assign cnt_nx   = (cnt_q == CNT_W'(OSR - 1)) ? '0 : cnt_q + CNT_W'(1);

  srx_vote #(.OSR(OSR)) u_vote (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .active_i (sampling),
    .cnt_i    (cnt_q),
    .line_i   (line_i),
    .decide_o (decide),
    .bit_o    (bit_v),
    .noisy_o  (noisy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      bits_q      <= IDX_W'(MIN_BITS);
      par_en_q    <= 1'b0;
      par_odd_q   <= 1'b0;
      par_bit_q   <= 1'b0;
      noise_acc_q <= 1'b0;
      data_o      <= '0;
      flags_o     <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        cnt_q <= cnt_nx;
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!line_i) begin
              state_q     <= ST_START;
              cnt_q       <= CNT_W'(1);
              idx_q       <= '0;
              data_o      <= '0;
              noise_acc_q <= 1'b0;
              par_en_q    <= cfg_par_en_i;
              par_odd_q   <= cfg_par_odd_i;
              if (cfg_bits_i < IDX_W'(MIN_BITS))      bits_q <= IDX_W'(MIN_BITS);
              else if (cfg_bits_i > IDX_W'(MAX_BITS)) bits_q <= IDX_W'(MAX_BITS);
              else                                    bits_q <= cfg_bits_i;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_W'(MID) && line_i) state_q <= ST_IDLE;
            else if (cnt_q == CNT_W'(OSR - 1))  state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (decide) begin
              data_o[idx_q] <= bit_v;
              noise_acc_q   <= noise_acc_q | noisy;
            end
            if (cnt_q == CNT_W'(OSR - 1)) begin
              if (idx_q == bits_q - IDX_W'(1)) state_q <= par_en_q ? ST_PAR : ST_STOP;
              else idx_q <= idx_q + IDX_W'(1);
            end
          end
          ST_PAR: begin
            if (decide) begin
              par_bit_q   <= bit_v;
              noise_acc_q <= noise_acc_q | noisy;
            end
            if (cnt_q == CNT_W'(OSR - 1)) state_q <= ST_STOP;
          end
          ST_STOP: begin
            if (decide) begin
              done_o            <= 1'b1;
              flags_o.frame_err <= ~bit_v;
              flags_o.noise     <= noise_acc_q | noisy;
              flags_o.par_err   <= par_en_q & (^data_o ^ par_bit_q ^ par_odd_q);
              state_q           <= ST_IDLE;  // rearm after first stop bit
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_start_abort_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_q == ST_START && cnt_q == CNT_W'(MID) && line_i |=> state_q == ST_IDLE);

  p_idx_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> idx_q < bits_q);

  p_done_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) == ST_STOP && state_q == ST_IDLE);

  p_no_parity_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !par_en_q |-> !flags_o.par_err);

endmodule

// File: rtl/srx_hold.sv
module srx_hold import srx_pkg::*; #(
  parameter int MAX_BITS = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  rx_flags_t           flags_i,
  input  logic                ack_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output rx_flags_t           flags_o,
  output logic                overrun_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      flags_o   <= '0;
      overrun_o <= 1'b0;
    end else if (done_i) begin
      if (!valid_o || ack_i) begin
        data_o    <= data_i;
        flags_o   <= flags_i;
        valid_o   <= 1'b1;
        overrun_o <= 1'b0;
      end else begin
        overrun_o <= 1'b1;  // new character dropped
      end
    end else if (valid_o && ack_i) begin
      valid_o   <= 1'b0;
      flags_o   <= '0;
      overrun_o <= 1'b0;
    end
  end

  p_hold_until_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(data_o));

  p_flags_need_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(flags_o.frame_err || flags_o.par_err || flags_o.noise || overrun_o));

  p_overrun_mark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i && done_i |=> overrun_o && $stable(data_o));

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx import srx_pkg::*; #(
  parameter  int OSR         = 16,
  parameter  int MIN_BITS    = 5,
  parameter  int MAX_BITS    = 9,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic [IDX_W-1:0]    cfg_bits_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_odd_i,
  input  logic                ack_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                par_err_o,
  output logic                noise_o,
  output logic                overrun_o
);

  logic                line_s, done;
  logic [MAX_BITS-1:0] frame_data;
  rx_flags_t           frame_flags, held_flags;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (line_s)
  );

  srx_frame #(.OSR(OSR), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .line_i        (line_s),
    .cfg_bits_i    (cfg_bits_i),
    .cfg_par_en_i  (cfg_par_en_i),
    .cfg_par_odd_i (cfg_par_odd_i),
    .done_o        (done),
    .data_o        (frame_data),
    .flags_o       (frame_flags)
  );

  srx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (frame_data),
    .flags_i   (frame_flags),
    .ack_i     (ack_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .flags_o   (held_flags),
    .overrun_o (overrun_o)
  );

  assign frame_err_o = held_flags.frame_err;
  assign par_err_o   = held_flags.par_err;
  assign noise_o     = held_flags.noise;

endmodule

// File: tb/sim_async_char_rx.sv
module sim_async_char_rx;

  typedef struct {
    logic [8:0] d;
    logic       fe, pe, nz, ov;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni, tick_i, rx_i, cfg_par_en_i, cfg_par_odd_i, ack_i;
  logic [3:0] cfg_bits_i;
  logic [8:0] data_o;
  logic       valid_o, frame_err_o, par_err_o, noise_o, overrun_o;
  logic [2:0] tick_cnt;
  bit         mon_en;
  int         n_chk, n_fail;
  exp_t       exp_q[$];

  always #10 clk = ~clk;

  always_ff @(posedge clk) tick_cnt <= (tick_cnt == 3'd4) ? 3'd0 : tick_cnt + 3'd1;
  assign tick_i = (tick_cnt == 3'd4);

  async_char_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .cfg_bits_i(cfg_bits_i), .cfg_par_en_i(cfg_par_en_i), .cfg_par_odd_i(cfg_par_odd_i),
    .ack_i(ack_i), .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
    .par_err_o(par_err_o), .noise_o(noise_o), .overrun_o(overrun_o)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick_i) @(negedge clk);
    @(negedge clk);
  endtask

  // one bit = 16 slots; slot s is seen by receiver tick s of that bit
  task automatic drive_bit(input logic v, input int glitch_slot);
    for (int s = 0; s < 16; s++) begin
      rx_i = (s == glitch_slot) ? ~v : v;
      wait_tick();
    end
  endtask

  task automatic idle_ticks(input int n);
    rx_i = 1'b1;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // gbit: frame position of glitch (0 start, 1..nb data, then parity, then stop)
  task automatic send_char(input logic [8:0] d, input int cfg_nb, input int nb,
                           input bit pen, input bit podd, input bit pflip,
                           input bit stop_lo, input int nstop,
                           input int gbit, input int gslot, input bit ov, input bit push);
    exp_t e;
    logic [8:0] m;
    logic p;
    int pos;
    m = d & 9'((1 << nb) - 1);
    p = ((^m) ^ podd) ^ pflip;
    e.d = m; e.fe = stop_lo; e.pe = pflip & pen; e.ov = ov;
    e.nz = (gbit >= 0) && (gslot >= 7) && (gslot <= 9);
    if (push) exp_q.push_back(e);
    cfg_bits_i = 4'(cfg_nb); cfg_par_en_i = pen; cfg_par_odd_i = podd;
    drive_bit(1'b0, (gbit == 0) ? gslot : -1);
    pos = 1;
    for (int i = 0; i < nb; i++) begin
      drive_bit(m[i], (gbit == pos) ? gslot : -1);
      pos++;
    end
    if (pen) begin
      drive_bit(p, (gbit == pos) ? gslot : -1);
      pos++;
    end
    drive_bit(~stop_lo, (gbit == pos) ? gslot : -1);
    for (int i = 1; i < nstop; i++) drive_bit(1'b1, -1);
    rx_i = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en && valid_o) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected character", 9'h1, 9'h0);
        end else begin
          e = exp_q.pop_front();
          chk("R2 data", data_o, e.d);
          chk("R6 frame_err", {8'h0, frame_err_o}, {8'h0, e.fe});
          chk("R5 par_err", {8'h0, par_err_o}, {8'h0, e.pe});
          chk("R4 noise", {8'h0, noise_o}, {8'h0, e.nz});
          chk("R9 overrun", {8'h0, overrun_o}, {8'h0, e.ov});
        end
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R8 valid clears after ack", {8'h0, valid_o}, 9'h0);
        chk("R8 flags clear after ack",
            {5'h0, frame_err_o, par_err_o, noise_o, overrun_o}, 9'h0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; mon_en = 1'b0;
    rst_ni = 1'b0; rx_i = 1'b1;
    cfg_bits_i = 4'd8; cfg_par_en_i = 1'b0; cfg_par_odd_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {8'h0, valid_o}, 9'h0);
    chk("R10 reset data", data_o, 9'h0);
    chk("R10 reset flags", {5'h0, frame_err_o, par_err_o, noise_o, overrun_o}, 9'h0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle_ticks(8);

    // R2 R3 plain formats
    send_char(9'h0A5, 8, 8, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h013, 5, 5, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h1C3, 9, 9, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    // R2 clamping: cfg 3 acts as 5, cfg 12 acts as 9
    send_char(9'h01E, 3, 5, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h12D, 12, 9, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    // R5 parity good even / odd, then bad
    send_char(9'h035, 7, 7, 1, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h05A, 8, 8, 1, 1, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h0C7, 8, 8, 1, 0, 1, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    send_char(9'h081, 6, 6, 1, 1, 1, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    // R6 framing error
    send_char(9'h03C, 8, 8, 0, 0, 0, 1, 1, -1, -1, 0, 1); idle_ticks(20);
    // R4 R3 noise on data bit 3 at tick 8, on stop at tick 7, on parity at tick 9
    send_char(9'h0F0, 8, 8, 0, 0, 0, 0, 1, 4, 8, 0, 1); idle_ticks(4);
    send_char(9'h066, 8, 8, 0, 0, 0, 0, 1, 9, 7, 0, 1); idle_ticks(4);
    send_char(9'h099, 8, 8, 1, 0, 0, 0, 1, 9, 9, 0, 1); idle_ticks(4);
    // R3 disturbance outside sampling window ignored
    send_char(9'h0AA, 8, 8, 0, 0, 0, 0, 1, 2, 6, 0, 1); idle_ticks(4);
    drain();

    // R1 false start: low for 6 slots only
    rx_i = 1'b0;
    for (int i = 0; i < 6; i++) wait_tick();
    idle_ticks(40);
    chk("R1 false start gives no character", {8'h0, valid_o}, 9'h0);
    chk("R1 no pending expectation", 9'(exp_q.size()), 9'h0);
    send_char(9'h055, 8, 8, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    drain();

    // R7 two stop bits, back to back
    send_char(9'h011, 8, 8, 0, 0, 0, 0, 2, -1, -1, 0, 1);
    send_char(9'h122, 9, 9, 1, 1, 0, 0, 2, -1, -1, 0, 1);
    send_char(9'h033, 8, 8, 0, 0, 0, 0, 2, -1, -1, 0, 1);
    idle_ticks(4);
    drain();

    // R9 overrun: hold off acknowledge over two characters
    mon_en = 1'b0;
    send_char(9'h0E1, 8, 8, 0, 0, 0, 0, 1, -1, -1, 1, 1); idle_ticks(2);
    send_char(9'h01F, 8, 8, 0, 0, 0, 0, 1, -1, -1, 0, 0); idle_ticks(4);
    chk("R9 held character still valid", {8'h0, valid_o}, 9'h1);
    mon_en = 1'b1;
    drain();
    chk("R9 second character lost", {8'h0, valid_o}, 9'h0);
    send_char(9'h07E, 8, 8, 0, 0, 0, 0, 1, -1, -1, 0, 1); idle_ticks(4);
    drain();

    chk("R7 all expected characters seen", 9'(exp_q.size()), 9'h0);
    summary();
  end

endmodule